// File: doc/BRIEF.md
# Gated serial word transmitter

This block sits on the controlling side of a three-wire serial output link and sends one data word per transfer to a peripheral. A transfer is framed by an active-low gate line. A burst clock made of low-going pulses times the data, and the receiver takes each bit on a falling clock edge. A data line carries the word, most significant bit first. All line timing comes from the system clock: a bit interval lasts `TB_TICKS` system clocks, and each clock pulse is half a bit interval low and half a bit interval high.

The user side loads a word and a gap count with a one-cycle start strobe. It watches `busy_o` to see when the block will accept another start, and `done_o` to learn that the word has left. The block spaces transfers itself. Half a bit interval passes between the gate falling and the first clock fall, and again between the last clock fall and the gate rising. The gate then stays high for a full bit interval of recovery, so gate falls are never closer than seventeen bit intervals. An optional stretch can be added to the high time between the eighth and ninth clock pulses, so that the word can pass as two byte bursts.

Top module: `gsw_tx`

## Requirements
- R1: `gate_no` is high out of reset and while idle. It goes low in the cycle after a start is accepted and stays low until the end of the transfer.
- R2: A transfer has exactly `WORD_W` low-going pulses on `sclk_o`. Each pulse is low for `TB_TICKS/2` cycles, and the high time between pulses is `TB_TICKS/2` cycles, apart from the stretched gap of R5. `sclk_o` is high whenever `gate_no` is high.
- R3: The first `sclk_o` fall comes `TB_TICKS/2` cycles after `gate_no` falls. `gate_no` rises `TB_TICKS/2` cycles after the last clock fall, on the same cycle as the final clock rise.
- R4: `word_i[WORD_W-1]` appears on `sdata_o` in the cycle `gate_no` falls. Each following bit, from higher to lower index, appears on a clock rise, which is half a bit interval after the previous fall and half a bit interval before the next one.
- R5: `gap_i` is latched when a start is accepted. That many extra cycles are added to the clock high time between pulse `WORD_W/2` and pulse `WORD_W/2+1`. A value of 0 adds none.
- R6: After `gate_no` rises, it stays high for `TB_TICKS` cycles before it can fall again. Falls of `gate_no` are at least `17*TB_TICKS` cycles apart.
- R7: `busy_o` is high from the cycle after an accepted start through the whole recovery interval. A start while `busy_o` is high is ignored, and changes to `word_i` or `gap_i` during a transfer do not affect it.
- R8: `done_o` is a one-cycle pulse, high in the cycle after the cycle in which `gate_no` rises.
- R9: During reset, `gate_no`=1, `sclk_o`=1, `sdata_o`=0, `busy_o`=0 and `done_o`=0.
- R10: `sdata_o` is low while no transfer is in progress, including during recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when idle |
| word_i | input | WORD_W | Word to send; the highest index goes first |
| gap_i | input | GAP_W | Extra high cycles after the middle pulse |
| busy_o | output | 1 | Transfer or recovery in progress |
| done_o | output | 1 | One-cycle pulse after the gate rises |
| gate_no | output | 1 | Transfer gate, active low |
| sclk_o | output | 1 | Burst clock, low-going pulses |
| sdata_o | output | 1 | Serial data |

## Verification
The bench holds start high through back-to-back transfers. A design that reopened the gate too early would break the seventeen-interval spacing and fall out of step with the model. It also pulses start and changes the word and gap in the middle of a transfer, which catches a design that restarts or relatches. Gap values of zero and non-zero check that the stretch falls only between the middle pair of pulses. An off-by-one there would shift every later clock edge. Words that are all ones, all zeros or alternating check the bit order and the moment each bit changes. Any swap of bits, or an update on the falling edge, shows up on the data line in the cycle it happens.

// File: rtl/gsw_pkg.sv
package gsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_RECOV = 3'd4
  } gsw_state_e;
endpackage

// File: rtl/gsw_timer.sv
module gsw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             end_o
);
  logic [CNT_W-1:0] cnt_q;

  assign end_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (end_o)     cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gsw_shifter.sv
module gsw_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= word_i;
    else if (shift_i)  sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[WORD_W-1];
endmodule

// File: rtl/gsw_ctrl.sv
module gsw_ctrl
  import gsw_pkg::*;
#(
  parameter int TB_TICKS = 8,
  parameter int WORD_W   = 16,
  parameter int GAP_W    = 6,
  parameter int CNT_W    = 8,
  parameter int IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             phase_end_i,
  output logic             run_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             drive_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             gate_no,
  output logic             sclk_o
);
  localparam int HALF = TB_TICKS / 2;
  localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] REC_LIM  = CNT_W'(TB_TICKS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] MID_IDX  = IDX_W'(WORD_W / 2 - 1);

  gsw_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [GAP_W-1:0] gap_q;
  logic             gate_q, sclk_q, drive_q, rise_q, done_q;
  logic             accept, last_low;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign last_low = (state_q == ST_LOW) && phase_end_i && (idx_q == LAST_IDX);

  always_comb begin
    limit_o = '0;
    unique case (state_q)
      ST_LEAD, ST_LOW: limit_o = HALF_LIM;
      ST_HIGH:         limit_o = (idx_q == MID_IDX) ? HALF_LIM + CNT_W'(gap_q) : HALF_LIM;
      ST_RECOV:        limit_o = REC_LIM;
      default:         limit_o = '0;
    endcase
  end

  assign run_o   = (state_q != ST_IDLE);
  assign load_o  = accept;
  assign shift_o = (state_q == ST_LOW) && phase_end_i && (idx_q != LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      gap_q   <= '0;
      gate_q  <= 1'b1;
      sclk_q  <= 1'b1;
      drive_q <= 1'b0;
      rise_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      rise_q <= last_low;
      done_q <= rise_q;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_LEAD;
          gate_q  <= 1'b0;
          drive_q <= 1'b1;
          idx_q   <= '0;
          gap_q   <= gap_i;
        end
        ST_LEAD: if (phase_end_i) begin
          state_q <= ST_LOW;
          sclk_q  <= 1'b0;
        end
        ST_LOW: if (phase_end_i) begin
          sclk_q <= 1'b1;
          if (idx_q == LAST_IDX) begin
            state_q <= ST_RECOV;
            gate_q  <= 1'b1;
            drive_q <= 1'b0;
          end else begin
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: if (phase_end_i) begin
          state_q <= ST_LOW;
          sclk_q  <= 1'b0;
          idx_q   <= idx_q + 1'b1;
        end
        ST_RECOV: if (phase_end_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_o = drive_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign gate_no = gate_q;
  assign sclk_o  = sclk_q;
endmodule

// File: rtl/gsw_tx.sv
module gsw_tx #(
  parameter int TB_TICKS = 8,
  parameter int WORD_W   = 16,
  parameter int GAP_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [GAP_W-1:0]  gap_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              gate_no,
  output logic              sclk_o,
  output logic              sdata_o
);
  localparam int CNT_W = $clog2(TB_TICKS + (1 << GAP_W) + 1);
  localparam int IDX_W = $clog2(WORD_W);

  logic             run, phase_end, load, shift, drive, msb;
  logic [CNT_W-1:0] limit;

  gsw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .limit_i (limit),
    .end_o   (phase_end)
  );

  gsw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .word_i  (word_i),
    .msb_o   (msb)
  );

  gsw_ctrl #(
    .TB_TICKS (TB_TICKS),
    .WORD_W   (WORD_W),
    .GAP_W    (GAP_W),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .gap_i       (gap_i),
    .phase_end_i (phase_end),
    .run_o       (run),
    .limit_o     (limit),
    .load_o      (load),
    .shift_o     (shift),
    .drive_o     (drive),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .gate_no     (gate_no),
    .sclk_o      (sclk_o)
  );

  assign sdata_o = drive & msb;
endmodule

// File: rtl/gsw_tx_chk.sv
module gsw_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic gate_no,
  input logic sclk_o,
  input logic sdata_o
);
  a_r1_gate_fall_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_no) |-> $past(start_i));
  a_r2_clk_high_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_no |-> sclk_o);
  a_r3_clk_fall_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> !gate_no);
  a_r7_busy_in_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_no |-> busy_o);
  a_r8_done_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_no) |=> done_o);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_data_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sdata_o);
endmodule

bind gsw_tx gsw_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .gate_no (gate_no),
  .sclk_o  (sclk_o),
  .sdata_o (sdata_o)
);

// File: tb/gsw_tx_tb.sv
module gsw_tx_tb;
  localparam int TB  = 8;
  localparam int W   = 16;
  localparam int GW  = 6;
  localparam int HALF = TB / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] word = '0;
  logic [GW-1:0] gap = '0;
  logic busy, done, gate_n, sclk, sdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gsw_tx #(.TB_TICKS(TB), .WORD_W(W), .GAP_W(GW)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .word_i (word), .gap_i (gap),
    .busy_o (busy), .done_o (done), .gate_no (gate_n), .sclk_o (sclk), .sdata_o (sdata)
  );

  typedef struct packed {logic g; logic c; logic d; logic b; logic dn;} exp_t;
  exp_t q[$];
  logic cur_busy = 1'b0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp_min, input int exp_max);
    checks++;
    if (act < exp_min || act > exp_max) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d..%0d", req, $time, act, exp_min, exp_max);
    end
  endtask

  // reference model: expected outputs for each cycle after an accepted start
  always @(posedge clk) begin
    if (rst_n && start && q.size() == 0 && !cur_busy) begin
      logic [W-1:0] w;
      int e;
      w = word;
      e = int'(gap);
      for (int k = 0; k < HALF; k++) q.push_back('{1'b0, 1'b1, w[W-1], 1'b1, 1'b0});
      for (int i = 0; i < W; i++) begin
        for (int k = 0; k < HALF; k++) q.push_back('{1'b0, 1'b0, w[W-1-i], 1'b1, 1'b0});
        if (i < W - 1) begin
          int hl;
          hl = HALF + ((i == W/2 - 1) ? e : 0);
          for (int k = 0; k < hl; k++) q.push_back('{1'b0, 1'b1, w[W-2-i], 1'b1, 1'b0});
        end
      end
      for (int r = 0; r < TB; r++) q.push_back('{1'b1, 1'b1, 1'b0, 1'b1, (r == 1)});
    end
  end

  int cyc = 0;
  int last_fall = -1;
  int pulses = 0;
  logic gate_d = 1'b1, sclk_d = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      cyc++;
      if (q.size() != 0) e = q.pop_front();
      else e = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
      cur_busy = e.b;
      chk("R1 gate", gate_n, e.g);
      chk("R2/R3/R5 clock", sclk, e.c);
      chk("R4/R10 data", sdata, e.d);
      chk("R7 busy", busy, e.b);
      chk("R8 done", done, e.dn);
      if (!sclk && sclk_d && !gate_n) pulses++;
      if (!gate_n && gate_d) begin
        if (last_fall >= 0) chk_int("R6 gate fall spacing", cyc - last_fall, 17*TB, 1000000);
        last_fall = cyc;
        pulses = 0;
      end
      if (gate_n && !gate_d) chk_int("R2 pulse count", pulses, W, W);
      gate_d = gate_n;
      sclk_d = sclk;
    end
  end

  task automatic send(input logic [W-1:0] w, input logic [GW-1:0] g);
    @(negedge clk);
    word = w; gap = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset gate", gate_n, 1'b1);
    chk("R9 reset clock", sclk, 1'b1);
    chk("R9 reset data", sdata, 1'b0);
    chk("R9 reset busy", busy, 1'b0);
    chk("R9 reset done", done, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(16'hA5C3, 6'd0); wait_idle();
    send(16'h8001, 6'd5); wait_idle();
    send(16'hFFFF, 6'd0); wait_idle();
    send(16'h0000, 6'd1); wait_idle();

    // R7: starts and input changes during a transfer are ignored
    send(16'h3C96, 6'd3);
    repeat (40) @(negedge clk);
    word = 16'h0F0F; gap = 6'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    start = 1'b1; word = 16'h1234;
    @(negedge clk); start = 1'b0;
    wait_idle();

    // R6: start held high, transfers run back to back
    word = 16'h5AA5; gap = 6'd2; start = 1'b1;
    repeat (3 * 17 * TB + 40) @(negedge clk);
    start = 1'b0;
    wait_idle();
    send(16'h7FFE, 6'd63); wait_idle();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule